// File: doc/BRIEF.md
# Host Command FIFO with Masked Interrupts

This block carries command bytes from a host to a local controller. The host pushes bytes into a 12-entry FIFO and the local controller pops them; a pop returns its byte on `loc_rd_data` one cycle later. When a pop takes the last stored byte, a command status flag goes high to tell the local controller that the command has been fully consumed. Further pops from the empty FIFO return FFh and change nothing else. A host push to a full FIFO is dropped and recorded in a sticky overflow flag.

Four status bits are kept: command, data-end, decoder and overflow. The data-end and decoder bits are set by single-cycle event pulses from outside. A local interrupt output is active high. It is the OR of the command, data-end and decoder bits, each gated by its own enable bit. The enables only gate the pin: writing them never alters a status bit, and a pending bit reappears on the pin as soon as it is enabled again. The local controller clears status bits with a write-one-to-clear strobe. A new host byte also clears the command bit.

Every host push also yields a one-cycle command-break pulse for the transfer engines, unless a break-disable control bit is set. The break has no path into the data-end status.

Top module: `hcf_cmd_path`

## Requirements
- R1: Bytes pushed by the host leave in the same order, up to DEPTH (12) stored. A pop accepted at an edge shows its byte on `loc_rd_data` after that edge, and the byte is held until the next pop.
- R2: A pop that takes the last stored byte, with no push at the same edge, sets status bit 0 (command flag).
- R3: A pop from an empty FIFO returns FFh on `loc_rd_data` and leaves the level and all status bits unchanged.
- R4: An accepted host push clears status bit 0. Writing `clr_we` with `clr_bits[i]`=1 clears status bit i for i = 0..3.
- R5: A push while the FIFO is full, with no pop at the same edge, is discarded and sets sticky status bit 3 (overflow). The FIFO contents and the level stay unchanged.
- R6: A `dte_evt` pulse sets status bit 1 and a `dec_evt` pulse sets status bit 2. A set at the same edge as a clear of that bit wins.
- R7: `irq` equals (st[0]&en[0]) | (st[1]&en[1]) | (st[2]&en[2]). The enables are `cfg_data` bit 0 (command), bit 1 (data-end) and bit 2 (decoder), stored on `cfg_we`. Status bit 3 never drives `irq`.
- R8: Writing the configuration never changes any status bit. A bit that is pending while masked drives `irq` again once it is re-enabled.
- R9: `cmd_break` is high for exactly one cycle after an edge with `host_wr`, and only when configuration bit 3 (break disable) is 0. A push to a full FIFO still breaks.
- R10: A command break never sets status bit 1.
- R11: Reset leaves the FIFO empty, all status and configuration bits at 0, `irq` and `cmd_break` low, and `loc_rd_data` at FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host push strobe |
| host_data | input | WIDTH | Host command byte |
| loc_rd | input | 1 | Local controller pop strobe |
| loc_rd_data | output | WIDTH | Popped byte, FFh on an empty pop |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored bytes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 4 | Enables in bits 0..2, break disable in bit 3 |
| dte_evt | input | 1 | Data-end event pulse |
| dec_evt | input | 1 | Decoder event pulse |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 4 | Write-one-to-clear mask for the status bits |
| status | output | 4 | Command, data-end, decoder and overflow bits (bits 0..3) |
| irq | output | 1 | Masked local interrupt, active high |
| cmd_break | output | 1 | One-cycle command-break pulse |

## Verification
The bench builds the block at the default DEPTH=12 and WIDTH=8. At that size one fill of 12 distinct bytes, plus one more push, reaches the full boundary, the overflow drop and pointer wrap at a depth that is not a power of two. It then sweeps all 8 combinations of the three interrupt-capable status bits against all 16 configuration values, so every mask and break-disable combination is compared with an independently computed `irq`. The bench also makes simultaneous set and clear, the empty pop and the break-disable toggle happen directly.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int ST_CMD = 0;
  localparam int ST_DTE = 1;
  localparam int ST_DEC = 2;
  localparam int ST_OVF = 3;
  localparam int CFG_BRK_DIS = 3;

  // masked interrupt: only the three event bits may reach the pin
  function automatic logic masked_irq(input logic [3:0] st, input logic [2:0] en);
    return |(st[2:0] & en);
  endfunction
endpackage

// File: rtl/hcf_fifo.sv
module hcf_fifo #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       push_ok,
  output logic                       last_pop,
  output logic                       drop_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             full, empty, pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign pop_ok   = rd_en && !empty;
  assign push_ok  = wr_en && (!full || pop_ok);
  assign drop_evt = wr_en && !push_ok;
  assign last_pop = pop_ok && !push_ok && (level == LW'(1));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      rd_data <= '1;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok) begin
        rp      <= ptr_next(rp);
        rd_data <= mem[rp];
      end else if (rd_en) begin
        rd_data <= '1;
      end
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R3
  empty_pop_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (rd_data == '1 && level == '0));
  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (level == $past(level)));
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/hcf_status.sv
module hcf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_cmd,
  input  logic       host_push,
  input  logic       set_dte,
  input  logic       set_dec,
  input  logic       set_ovf,
  input  logic       clr_we,
  input  logic [3:0] clr_bits,
  output logic [3:0] st
);
  import hcf_pkg::*;

  logic [3:0] set_v, clr_v;

  always_comb begin
    set_v         = '0;
    set_v[ST_CMD] = set_cmd;
    set_v[ST_DTE] = set_dte;
    set_v[ST_DEC] = set_dec;
    set_v[ST_OVF] = set_ovf;
    clr_v         = clr_we ? clr_bits : 4'b0;
    clr_v[ST_CMD] = clr_v[ST_CMD] | host_push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= set_v | (st & ~clr_v);
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_dte |=> st[ST_DTE]);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[ST_OVF] && !(clr_we && clr_bits[ST_OVF])) |=> st[ST_OVF]);
endmodule

// File: rtl/hcf_cmd_path.sv
module hcf_cmd_path #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic [WIDTH-1:0]           host_data,
  input  logic                       loc_rd,
  output logic [WIDTH-1:0]           loc_rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_data,
  input  logic                       dte_evt,
  input  logic                       dec_evt,
  input  logic                       clr_we,
  input  logic [3:0]                 clr_bits,
  output logic [3:0]                 status,
  output logic                       irq,
  output logic                       cmd_break
);
  import hcf_pkg::*;

  logic [3:0] cfg_q;
  logic       push_ok, last_pop, drop_evt;
  logic       brk_req;

  hcf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr), .wr_data(host_data),
    .rd_en(loc_rd), .rd_data(loc_rd_data), .level(fifo_level),
    .push_ok(push_ok), .last_pop(last_pop), .drop_evt(drop_evt)
  );

  hcf_status status_i (
    .clk(clk), .rst_n(rst_n),
    .set_cmd(last_pop), .host_push(push_ok),
    .set_dte(dte_evt), .set_dec(dec_evt), .set_ovf(drop_evt),
    .clr_we(clr_we), .clr_bits(clr_bits), .st(status)
  );

  assign brk_req = host_wr && !cfg_q[CFG_BRK_DIS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cmd_break <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_data;
      cmd_break <= brk_req;
    end
  end

  assign irq = masked_irq(status, cfg_q[2:0]);

  // R9
  break_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !cfg_q[CFG_BRK_DIS]) |=> cmd_break);
  // R10
  break_no_dte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !dte_evt) |=> !$rose(status[ST_DTE]));
  // R8
  cfg_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !host_wr && !loc_rd && !dte_evt && !dec_evt && !clr_we)
      |=> $stable(status));
  // R7
  ovf_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2:0] == 3'b000) |-> !irq);
endmodule

// File: tb/hcf_cmd_path_tb_top.sv
module hcf_cmd_path_tb_top;
  localparam int DEPTH = 12;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, loc_rd = 0, cfg_we = 0, dte_evt = 0, dec_evt = 0, clr_we = 0;
  logic [WIDTH-1:0] host_data = '0;
  logic [3:0] cfg_data = '0, clr_bits = '0;
  logic [WIDTH-1:0] loc_rd_data;
  logic [$clog2(DEPTH+1)-1:0] fifo_level;
  logic [3:0] status;
  logic irq, cmd_break;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hcf_cmd_path #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .loc_rd(loc_rd), .loc_rd_data(loc_rd_data), .fifo_level(fifo_level),
    .cfg_we(cfg_we), .cfg_data(cfg_data), .dte_evt(dte_evt), .dec_evt(dec_evt),
    .clr_we(clr_we), .clr_bits(clr_bits), .status(status), .irq(irq),
    .cmd_break(cmd_break)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic push(input logic [7:0] d);
    host_wr = 1; host_data = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic pop();
    loc_rd = 1;
    @(negedge clk);
    loc_rd = 0;
  endtask

  task automatic set_cfg(input logic [3:0] v);
    cfg_we = 1; cfg_data = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear(input logic [3:0] m);
    clr_we = 1; clr_bits = m;
    @(negedge clk);
    clr_we = 0; clr_bits = 0;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] st_exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(fifo_level == 0 && status == 0 && !irq && !cmd_break && loc_rd_data == 8'hFF,
        "R11", {status, 3'b0, irq, 3'b0, cmd_break}, 0);

    // R1 R5 R9 fill, overflow, break per push
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i));
      chk(cmd_break == 1, "R9", cmd_break, 1);
    end
    chk(fifo_level == DEPTH, "R1", fifo_level, DEPTH);
    push(8'hA5);
    chk(fifo_level == DEPTH, "R5", fifo_level, DEPTH);
    chk(status[3] == 1, "R5", status, 8);
    chk(cmd_break == 1, "R9", cmd_break, 1);
    @(negedge clk);
    chk(cmd_break == 0, "R9", cmd_break, 0);
    chk(irq == 0, "R7", irq, 0);

    // R1 R2 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk(loc_rd_data == pat(i), "R1", loc_rd_data, pat(i));
      chk(status[0] == (i == DEPTH-1), "R2", status[0], (i == DEPTH-1));
    end
    @(negedge clk);
    chk(loc_rd_data == pat(DEPTH-1), "R1", loc_rd_data, pat(DEPTH-1));
    // R3 empty pop
    pop();
    chk(loc_rd_data == 8'hFF, "R3", loc_rd_data, 8'hFF);
    chk(fifo_level == 0 && status == 4'b1001, "R3", status, 9);
    // R4 push clears command bit; W1C clears overflow
    push(8'h3C);
    chk(status == 4'b1000, "R4", status, 8);
    clear(4'b1000);
    chk(status == 0, "R4", status, 0);
    // R1 wrap: simultaneous push and pop at level 1
    host_wr = 1; host_data = 8'h77; loc_rd = 1;
    @(negedge clk);
    host_wr = 0; loc_rd = 0;
    chk(loc_rd_data == 8'h3C && fifo_level == 1, "R1", loc_rd_data, 8'h3C);
    chk(status[0] == 0, "R2", status[0], 0);
    pop();
    chk(loc_rd_data == 8'h77 && status[0] == 1, "R2", loc_rd_data, 8'h77);

    // R6 set wins over clear
    clear(4'b1111);
    dte_evt = 1; clr_we = 1; clr_bits = 4'b0010;
    @(negedge clk);
    dte_evt = 0; clr_we = 0; clr_bits = 0;
    chk(status == 4'b0010, "R6", status, 2);
    dec_evt = 1;
    @(negedge clk);
    dec_evt = 0;
    chk(status == 4'b0110, "R6", status, 6);
    clear(4'b0110);
    chk(status == 0, "R4", status, 0);

    // R10 break does not raise data-end
    set_cfg(4'b0000);
    push(8'h11);
    chk(cmd_break == 1 && status[1] == 0, "R10", status, 0);
    set_cfg(4'b1000);
    push(8'h22);
    chk(cmd_break == 0, "R9", cmd_break, 0);
    pop(); pop();
    clear(4'b1111);

    // R7 R8 sweep status combos x config values
    for (int s = 0; s < 8; s++) begin
      clear(4'b1111);
      if (s[0]) begin push(8'h55); pop(); end
      if (s[1]) begin dte_evt = 1; @(negedge clk); dte_evt = 0; end
      if (s[2]) begin dec_evt = 1; @(negedge clk); dec_evt = 0; end
      st_exp = 4'(s);
      for (int m = 0; m < 16; m++) begin
        bit e;
        set_cfg(4'(m));
        e = 0;
        for (int b = 0; b < 3; b++) if (((s >> b) & 1) == 1 && ((m >> b) & 1) == 1) e = 1;
        chk(status == st_exp, "R8", status, st_exp);
        chk(irq == e, "R7", irq, e);
      end
    end
    // R8 pending bit returns on re-enable
    set_cfg(4'b0000);
    chk(irq == 0, "R8", irq, 0);
    set_cfg(4'b0100);
    chk(irq == 1, "R8", irq, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule